// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a register-mapped general-purpose I/O controller serving up to 128 pins, organised as four banks of 32. Software picks each pin's direction and drives its output level only through a pair of write-only registers: one sets bits and one clears them. Each input passes through a two-flop synchronizer. A rising or falling transition on it can latch a status bit, and each edge polarity has its own per-pin enable.

Latched status drives three level interrupts. One serves pin 0, one serves pin 1, and one is shared by every other pin. A status bit stays set until software writes one to it. Each bank also stores two 32-bit alternate-function words, which give two bits per pin. Pad multiplexing and the peripherals those words would select are outside this block.

The bus side is a single 32-bit port. A write commits on the clock edge. Read data is combinational from the address.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe_o` and `pin_o` are all zero, and all three interrupts are low.
- R2: A write to the set register ORs the data into that bank's output level. A write to the clear register clears the level bits written as one. `pin_o` shows the output levels and `pin_oe_o` shows the direction bits (1 = output), both effective after the write's clock edge.
- R3: Reading the set register (code 2) or the clear register (code 3) returns zero.
- R4: The following registers read back their last written value: direction (code 1), rising enable (code 4), falling enable (code 5), alternate-function low word (code 7) and alternate-function high word (code 8).
- R5: A rising transition on a synchronized input sets that pin's status bit only when its rising-enable bit is one. The status bit is visible after the third clock edge following the pin change.
- R6: A falling transition sets the status bit only when the pin's falling-enable bit is one, with the same latency as R5.
- R7: Writing the status register (code 6) clears each bit written as one. Bits written as zero are unchanged.
- R8: `irq_pin0_o` follows status bit 0 of bank 0. `irq_pin1_o` follows status bit 1 of bank 0. `irq_rest_o` is the OR of all other status bits.
- R9: The level register (code 0) returns the output level for pins set as outputs, and the input after two synchronizer flops for pins set as inputs.
- R10: When an enabled edge and a write of one to the same status bit act on the same clock edge, the bit ends up set.
- R11: The byte address is decoded as follows. Bits [1:0] must be zero. Bits [3:2] select the bank. Bits [7:4] hold the register code. Bits [11:8] must be zero. Any other address or register code reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| pin_i | input | 128 | Pad input levels, asynchronous |
| pin_o | output | 128 | Output levels |
| pin_oe_o | output | 128 | Output enables (direction) |
| irq_pin0_o | output | 1 | Interrupt for pin 0 |
| irq_pin1_o | output | 1 | Interrupt for pin 1 |
| irq_rest_o | output | 1 | Shared interrupt for pins 2 to 127 |

## Verification
Edge capture and the write-one-to-clear of status can land on the same clock edge. The bench provokes this by raising an enabled pin one cycle after an edge, then timing a status write to commit on the third edge, which is when the edge is latched. The result is judged by reading status afterwards: the bit must still be set and its interrupt still high. Separate cases check that a clear alone does drop the bit, and that writing zero leaves it alone.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    REG_LEVEL  = 4'd0,
    REG_DIR    = 4'd1,
    REG_SET    = 4'd2,
    REG_CLR    = 4'd3,
    REG_RISE   = 4'd4,
    REG_FALL   = 4'd5,
    REG_STAT   = 4'd6,
    REG_ALT_LO = 4'd7,
    REG_ALT_HI = 4'd8
  } reg_sel_e;
  localparam int REG_SEL_W = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         pin_sync_i,
  input  logic                 wr_en_i,
  input  logic [REG_SEL_W-1:0] reg_sel_i,
  input  logic [W-1:0]         wdata_i,
  output logic [W-1:0]         dir_o,
  output logic [W-1:0]         out_o,
  output logic [W-1:0]         rise_en_o,
  output logic [W-1:0]         fall_en_o,
  output logic [W-1:0]         status_o,
  output logic [W-1:0]         alt_lo_o,
  output logic [W-1:0]         alt_hi_o,
  output logic [W-1:0]         level_o
);
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, alt_lo_q, alt_hi_q, prev_q;
  logic [W-1:0] rise_ev, fall_ev, w1c, stat_d;

  assign rise_ev = pin_sync_i & ~prev_q;
  assign fall_ev = ~pin_sync_i & prev_q;
  assign w1c     = (wr_en_i && reg_sel_i == REG_STAT) ? wdata_i : '0;
  // new edges win over a same-cycle clear
  assign stat_d  = (stat_q & ~w1c) | (rise_ev & rise_q) | (fall_ev & fall_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      out_q    <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      stat_q   <= '0;
      alt_lo_q <= '0;
      alt_hi_q <= '0;
      prev_q   <= '0;
    end else begin
      prev_q <= pin_sync_i;
      stat_q <= stat_d;
      if (wr_en_i) begin
        case (reg_sel_i)
          REG_DIR:    dir_q    <= wdata_i;
          REG_SET:    out_q    <= out_q | wdata_i;
          REG_CLR:    out_q    <= out_q & ~wdata_i;
          REG_RISE:   rise_q   <= wdata_i;
          REG_FALL:   fall_q   <= wdata_i;
          REG_ALT_LO: alt_lo_q <= wdata_i;
          REG_ALT_HI: alt_hi_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign dir_o     = dir_q;
  assign out_o     = out_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign status_o  = stat_q;
  assign alt_lo_o  = alt_lo_q;
  assign alt_hi_o  = alt_hi_q;
  assign level_o   = (dir_q & out_q) | (~dir_q & pin_sync_i);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
  output logic [NUM_BANKS*BANK_W-1:0] pin_o,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe_o,
  output logic                        irq_pin0_o,
  output logic                        irq_pin1_o,
  output logic                        irq_rest_o
);
  localparam int NUM_PINS = NUM_BANKS * BANK_W;
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int BANK_LSB = 2;
  localparam int REG_LSB = BANK_LSB + BANK_BITS;
  localparam int TOP_LSB = REG_LSB + REG_SEL_W;

  logic [BANK_BITS-1:0] bank_sel;
  logic [REG_SEL_W-1:0] reg_sel;
  logic                 hit;
  logic [NUM_PINS-1:0]  pin_sync, status_all, en_all;

  logic [BANK_W-1:0] dir_a [NUM_BANKS];
  logic [BANK_W-1:0] out_a [NUM_BANKS];
  logic [BANK_W-1:0] rise_a[NUM_BANKS];
  logic [BANK_W-1:0] fall_a[NUM_BANKS];
  logic [BANK_W-1:0] stat_a[NUM_BANKS];
  logic [BANK_W-1:0] alo_a [NUM_BANKS];
  logic [BANK_W-1:0] ahi_a [NUM_BANKS];
  logic [BANK_W-1:0] lvl_a [NUM_BANKS];

  assign bank_sel = addr_i[BANK_LSB +: BANK_BITS];
  assign reg_sel  = addr_i[REG_LSB +: REG_SEL_W];
  assign hit = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:TOP_LSB] == '0)
               && (int'(bank_sel) < NUM_BANKS);

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_b;
    assign wr_b = req_i && we_i && hit && (int'(bank_sel) == b);

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_sync_i(pin_sync[b*BANK_W +: BANK_W]),
      .wr_en_i   (wr_b),
      .reg_sel_i (reg_sel),
      .wdata_i   (wdata_i),
      .dir_o     (dir_a[b]),
      .out_o     (out_a[b]),
      .rise_en_o (rise_a[b]),
      .fall_en_o (fall_a[b]),
      .status_o  (stat_a[b]),
      .alt_lo_o  (alo_a[b]),
      .alt_hi_o  (ahi_a[b]),
      .level_o   (lvl_a[b])
    );

    assign pin_o[b*BANK_W +: BANK_W]      = out_a[b];
    assign pin_oe_o[b*BANK_W +: BANK_W]   = dir_a[b];
    assign status_all[b*BANK_W +: BANK_W] = stat_a[b];
    assign en_all[b*BANK_W +: BANK_W]     = rise_a[b] | fall_a[b];
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (reg_sel)
        REG_LEVEL:  rdata_o = lvl_a[bank_sel];
        REG_DIR:    rdata_o = dir_a[bank_sel];
        REG_RISE:   rdata_o = rise_a[bank_sel];
        REG_FALL:   rdata_o = fall_a[bank_sel];
        REG_STAT:   rdata_o = stat_a[bank_sel];
        REG_ALT_LO: rdata_o = alo_a[bank_sel];
        REG_ALT_HI: rdata_o = ahi_a[bank_sel];
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_pin0_o = status_all[0];
  assign irq_pin1_o = status_all[1];
  assign irq_rest_o = |status_all[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NUM_PINS = 128,
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [BANK_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_pin0_o,
  input logic [NUM_PINS-1:0] status_all,
  input logic [NUM_PINS-1:0] en_all
);
  // R3
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:8] == '0 && addr_i[1:0] == 2'b00 &&
     (addr_i[7:4] == 4'd2 || addr_i[7:4] == 4'd3)) |-> rdata_o == '0);

  // R2
  out_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_o) |-> $past(req_i && we_i));

  // R4
  dir_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_oe_o) |-> $past(req_i && we_i));

  // R7
  stat_clear_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(status_all) & ~status_all)) |-> $past(req_i && we_i));

  // R5
  stat_set_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_all & ~$past(status_all) & ~$past(en_all)) == '0);

  // R8
  irq0_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pin0_o) |-> $past(en_all[0]));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .irq_pin0_o(irq_pin0_o),
  .status_all(status_all),
  .en_all    (en_all)
);

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  localparam int NP = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o, pin_oe_o;
  logic          irq_pin0_o, irq_pin1_o, irq_rest_o;

  always #2 clk_i = ~clk_i;

  gpio_edge_ctrl u0 (.*);

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [11:0] adr(int r, int b);
    return {4'd0, 4'(r), 2'(b), 2'b00};
  endfunction

  // sel: 0 rdata, 1 irqs {rest,pin1,pin0}, 2 pin_o bank1, 3 pin_oe_o bank1
  task automatic expect_v(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(int r, int b, logic [31:0] d);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = adr(r, b); wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(int r, int b, logic [31:0] exp, string tag);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 0; addr_i = adr(r, b);
    expect_v(0, exp, tag);
  endtask

  task automatic obs(int sel, logic [31:0] exp, string tag);
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
    expect_v(sel, exp, tag);
  endtask

  task automatic set_pin(int p, logic v);
    @(posedge clk_i); #1;
    pin_i[p] = v;
    repeat (3) @(posedge clk_i);
  endtask

  // monitor
  always begin
    @(negedge clk_i); #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rdata_o;
        1: act = {29'd0, irq_rest_o, irq_pin1_o, irq_pin0_o};
        2: act = pin_o[63:32];
        default: act = pin_oe_o[63:32];
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i); #1;
    rst_ni = 1;
    // R1 reset state
    rd(1, 0, 32'h0, "R1 dir");
    rd(6, 3, 32'h0, "R1 status");
    rd(4, 2, 32'h0, "R1 rise_en");
    obs(1, 32'h0, "R1 irqs");
    obs(3, 32'h0, "R1 pin_oe");
    // R4 readback
    wr(1, 1, 32'hffff_ffff);
    wr(4, 2, 32'h1234_5000);
    wr(8, 3, 32'hdead_beef);
    wr(7, 0, 32'h0bad_f00d);
    rd(1, 1, 32'hffff_ffff, "R4 dir");
    rd(4, 2, 32'h1234_5000, "R4 rise_en");
    rd(8, 3, 32'hdead_beef, "R4 alt_hi");
    rd(7, 0, 32'h0bad_f00d, "R4 alt_lo");
    obs(3, 32'hffff_ffff, "R2 pin_oe");
    // R2 set/clear
    wr(2, 1, 32'h0000_00f0);
    wr(2, 1, 32'h0000_0f00);
    obs(2, 32'h0000_0ff0, "R2 set");
    wr(3, 1, 32'h0000_0030);
    obs(2, 32'h0000_0fc0, "R2 clr");
    rd(0, 1, 32'h0000_0fc0, "R9 output mirror");
    // R3
    rd(2, 1, 32'h0, "R3 set read");
    rd(3, 1, 32'h0, "R3 clr read");
    // R11 unmapped
    rd(9, 1, 32'h0, "R11 bad code");
    wr(5, 0, 32'h0000_0001);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = 12'h154; wdata_i = 32'hffff_ffff;
    @(posedge clk_i); #1; req_i = 0; we_i = 0;
    rd(5, 1, 32'h0, "R11 high addr write ignored");
    // R9 input sync, R5 gating
    set_pin(64 + 9, 1'b1);
    rd(0, 2, 32'h0000_0200, "R9 input level");
    rd(6, 2, 32'h0, "R5 disabled rise");
    set_pin(64 + 12, 1'b1);
    rd(6, 2, 32'h0000_1000, "R5 enabled rise");
    obs(1, 32'h4, "R8 irq_rest");
    // R7
    wr(6, 2, 32'h0);
    rd(6, 2, 32'h0000_1000, "R7 write zero");
    wr(6, 2, 32'h0000_1000);
    rd(6, 2, 32'h0, "R7 w1c");
    obs(1, 32'h0, "R8 irq_rest low");
    // R6 falling on pin 0, R5 rise on pin 1
    wr(5, 0, 32'h0000_0001);
    wr(4, 0, 32'h0000_0002);
    set_pin(0, 1'b1);
    rd(6, 0, 32'h0, "R6 rise on fall-only pin");
    set_pin(0, 1'b0);
    rd(6, 0, 32'h1, "R6 fall");
    obs(1, 32'h1, "R8 irq pin0");
    set_pin(1, 1'b1);
    obs(1, 32'h3, "R8 irq pin1");
    wr(6, 0, 32'h3);
    obs(1, 32'h0, "R7 clear irqs");
    set_pin(1, 1'b0);
    // R10 edge and clear on same edge
    @(posedge clk_i); #1;
    pin_i[1] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = adr(6, 0); wdata_i = 32'h2;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
    rd(6, 0, 32'h2, "R10 set wins");
    obs(1, 32'h2, "R10 irq pin1 held");
    wr(6, 0, 32'h2);
    rd(6, 0, 32'h0, "R10 later clear");
    repeat (3) @(posedge clk_i);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule